// File: doc/BRIEF.md
# Parallel ATA PIO Single-Word Transfer Engine

This block sits on the host side of a parallel ATA bus and carries out one 16-bit programmed-I/O access at a time. Software fills a small set of configuration registers: the device register number, the transfer direction, the word to send, and two sets of clock counts. It then writes the launch bit. The engine asserts the proper chip select and address lines and waits out an address setup time. It then pulses the read or write strobe for a programmed width and holds the cycle for a programmed recovery time. On a read it captures the bus word at the end of the strobe.

Device register 0 is the data port and uses its own strobe width and recovery counts. Every other register number uses the register-access counts. The address setup and write data hold counts are shared by both sets. When enabled, the device's ready line stretches the strobe. A bounded stretch limit stops a device that never becomes ready from hanging the bus. Completion sets a sticky done flag. Software clears it by writing a 1, and an interrupt mask can route it to an interrupt output.

Register numbers on the configuration port: 0 control (bit 0 launch, bit 1 direction with 1 for write, bit 2 use-DMA, bit 3 ready enable), 1 device register number, 2 transmit word, 3 receive word, 4 register timing ([15:8] strobe width, [7:0] recovery), 5 PIO timing ([15:12] write hold, [11:4] data-port recovery, [3:0] address setup), 6 data-port strobe width in bits [7:0], 7 status (bit 0 done, bit 1 stretch error, bit 2 busy), 8 interrupt mask (bit 0 enables done).

Top module: `pata_pio_engine`

## Requirements
- R1: After reset both chip selects are high (ata_cs_n = 2'b11), both strobes are high, ata_dd_oe is 0, irq is 0, and the status and interrupt mask registers (numbers 7 and 8) read as 0.
- R2: After a launch, the chip select and address are valid with both strobes high for max(S,1) clocks before the strobe, where S is bits [3:0] of register 5.
- R3: The strobe stays low for max(W,1) clocks. W is register 6 bits [7:0] when the device register number is 0, and register 4 bits [15:8] otherwise. Only one strobe is low at a time: ata_diow_n for writes and ata_dior_n for reads.
- R4: After the strobe the chip select stays asserted for max(E,1) clocks. E is register 5 bits [11:4] for device register 0, and register 4 bits [7:0] otherwise. Then the bus returns to idle.
- R5: Device register number bit 3 selects the chip select: 0 drives ata_cs_n = 2'b10 and 1 drives 2'b01. ata_da carries bits [2:0] for the whole cycle.
- R6: On a write, ata_dd_out equals the transmit word with ata_dd_oe high through setup and strobe. ata_dd_oe stays high for min(max(H,1), max(E,1)) clocks after the strobe, where H is register 5 bits [15:12]. On a read, ata_dd_oe stays low.
- R7: On a read, the value on ata_dd_in at the end of the strobe is readable from register 3 once the transfer is done.
- R8: Status bit 0 sets when a transfer ends and stays set. Writing 1 to it clears it, and writing 0 leaves it set.
- R9: irq is high exactly when status bit 0 and mask bit 0 are both 1.
- R10: With control bit 3 set, each clock that ata_iordy is sampled low during the strobe lengthens the strobe by one clock. With bit 3 clear, ata_iordy has no effect.
- R11: If the strobe is held by ata_iordy for STRETCH_MAX clocks, the strobe ends after STRETCH_MAX clocks and the recovery phase runs. Status bits 1 and 0 are then set, and the receive word is not updated.
- R12: A launch written while a transfer is in progress is ignored, and so is a launch written with control bit 2 set. Neither starts a bus cycle or changes the cycle already running.
- R13: Status bit 2 reads 1 while a transfer is in progress and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 4 | Configuration register number for writes |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_addr | input | 4 | Configuration register number for reads |
| cfg_rd_data | output | 16 | Registered read data, one clock after cfg_rd_addr |
| irq | output | 1 | Done interrupt, gated by mask bit 0 |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_da | output | 3 | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus outbound value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus inbound value |
| ata_iordy | input | 1 | Device ready, low requests a wait |

## Verification
A wrong phase count shows at the bus pins during the cycle it corrupts. A setup, strobe or recovery phase that runs one clock long or short gets counted at the pins before the cycle ends. A wrong selection between the data-port and register count sets, or a mislatched address, shows as a wrong pulse width or a wrong chip select on the first affected transfer. Sticky-flag and capture faults stay hidden until status or the receive word is read back. Each transfer in the sweep reads both, so such a fault is caught within one transfer.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

  localparam int REG_AW = 4;
  localparam int CNT_W  = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] OFS_DEV   = 4'd1;
  localparam logic [REG_AW-1:0] OFS_TX    = 4'd2;
  localparam logic [REG_AW-1:0] OFS_RX    = 4'd3;
  localparam logic [REG_AW-1:0] OFS_TREG  = 4'd4;
  localparam logic [REG_AW-1:0] OFS_TPIO0 = 4'd5;
  localparam logic [REG_AW-1:0] OFS_TPIO1 = 4'd6;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'd7;
  localparam logic [REG_AW-1:0] OFS_MASK  = 4'd8;

  localparam int CTRL_GO  = 0;
  localparam int CTRL_WR  = 1;
  localparam int CTRL_DMA = 2;
  localparam int CTRL_RDY = 3;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] recover;
    logic [CNT_W-1:0] hold;
  } phase_counts_t;

endpackage

// File: rtl/pata_pio_regs.sv
module pata_pio_regs
  import pata_pio_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              start_pulse,
  output logic              ctrl_wr,
  output logic              ctrl_dma,
  output logic              ctrl_rdy,
  output logic [3:0]        dev_addr,
  output logic [DW-1:0]     tx_word,
  output logic [15:0]       tim_reg,
  output logic [15:0]       tim_pio0,
  output logic [7:0]        tim_pio1,
  output logic              irq,
  input  logic              busy,
  input  logic              done_set,
  input  logic              err_set,
  input  logic              rx_load,
  input  logic [DW-1:0]     rx_word_in
);

  logic [DW-1:0] rx_q;
  logic          done_q, err_q, mask_q;
  logic          done_n, err_n, mask_n;
  logic          wr_stat, wr_mask;

  assign wr_stat = wr_en && (wr_addr == OFS_STAT);
  assign wr_mask = wr_en && (wr_addr == OFS_MASK);

  always_comb begin
    done_n = done_q;
    err_n  = err_q;
    mask_n = mask_q;
    if (wr_stat && wr_data[0]) done_n = 1'b0;
    if (wr_stat && wr_data[1]) err_n  = 1'b0;
    if (done_set)              done_n = 1'b1;
    if (err_set)               err_n  = 1'b1;
    if (wr_mask)               mask_n = wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_wr     <= 1'b0;
      ctrl_dma    <= 1'b0;
      ctrl_rdy    <= 1'b0;
      start_pulse <= 1'b0;
      dev_addr    <= '0;
      tx_word     <= '0;
      tim_reg     <= '0;
      tim_pio0    <= '0;
      tim_pio1    <= '0;
      rx_q        <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      mask_q      <= 1'b0;
      irq         <= 1'b0;
      rd_data     <= '0;
    end else begin
      start_pulse <= wr_en && (wr_addr == OFS_CTRL) && wr_data[CTRL_GO];
      if (wr_en) begin
        case (wr_addr)
          OFS_CTRL: begin
            ctrl_wr  <= wr_data[CTRL_WR];
            ctrl_dma <= wr_data[CTRL_DMA];
            ctrl_rdy <= wr_data[CTRL_RDY];
          end
          OFS_DEV:   dev_addr <= wr_data[3:0];
          OFS_TX:    tx_word  <= wr_data;
          OFS_TREG:  tim_reg  <= wr_data[15:0];
          OFS_TPIO0: tim_pio0 <= wr_data[15:0];
          OFS_TPIO1: tim_pio1 <= wr_data[7:0];
          default: ;
        endcase
      end
      if (rx_load) rx_q <= rx_word_in;
      done_q <= done_n;
      err_q  <= err_n;
      mask_q <= mask_n;
      irq    <= done_n && mask_n;
      case (rd_addr)
        OFS_CTRL:  rd_data <= DW'({ctrl_rdy, ctrl_dma, ctrl_wr, 1'b0});
        OFS_DEV:   rd_data <= DW'(dev_addr);
        OFS_TX:    rd_data <= tx_word;
        OFS_RX:    rd_data <= rx_q;
        OFS_TREG:  rd_data <= DW'(tim_reg);
        OFS_TPIO0: rd_data <= DW'(tim_pio0);
        OFS_TPIO1: rd_data <= DW'(tim_pio1);
        OFS_STAT:  rd_data <= DW'({busy, err_q, done_q});
        OFS_MASK:  rd_data <= DW'(mask_q);
        default:   rd_data <= '0;
      endcase
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(wr_stat && wr_data[0])) |=> done_q); // R8

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_q); // R9

endmodule

// File: rtl/pata_pio_timing_sel.sv
module pata_pio_timing_sel
  import pata_pio_pkg::*;
#(
  parameter logic [3:0] DATA_ADDR = 4'd0
) (
  input  logic [15:0]   tim_reg,
  input  logic [15:0]   tim_pio0,
  input  logic [7:0]    tim_pio1,
  input  logic [3:0]    dev_addr,
  output phase_counts_t counts
);

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  logic is_data;
  assign is_data = (dev_addr == DATA_ADDR);

  always_comb begin
    counts.setup   = at_least_one(CNT_W'(tim_pio0[3:0]));
    counts.hold    = at_least_one(CNT_W'(tim_pio0[15:12]));
    counts.strobe  = at_least_one(is_data ? tim_pio1 : tim_reg[15:8]);
    counts.recover = at_least_one(is_data ? tim_pio0[11:4] : tim_reg[7:0]);
  end

endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
  import pata_pio_pkg::*;
#(
  parameter int DW          = 16,
  parameter int STRETCH_MAX = 1250
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_wr,
  input  logic          use_dma,
  input  logic          rdy_en,
  input  logic [3:0]    dev_addr,
  input  logic [DW-1:0] tx_word,
  input  phase_counts_t counts,
  input  logic          iordy,
  input  logic [DW-1:0] dd_in,
  output logic [1:0]    cs_n,
  output logic [2:0]    da,
  output logic          dior_n,
  output logic          diow_n,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  output logic          busy,
  output logic          done_pulse,
  output logic          err_pulse,
  output logic          rx_load,
  output logic [DW-1:0] rx_word
);

  localparam int SW = $clog2(STRETCH_MAX + 1);

  phase_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SW-1:0]   stretch_q, stretch_d;
  logic            abort_q, abort_d;
  logic            launch;
  logic            sample_en;

  logic [3:0]      lat_addr_q, addr_d;
  logic            lat_dir_q, dir_d;
  logic            lat_rdy_q;
  logic [DW-1:0]   lat_tx_q, tx_d;
  phase_counts_t   lat_cnt_q, cnt_set_d;
  logic [DW-1:0]   sample_q;

  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] n);
    return ({1'b0, c} + 9'd1) >= {1'b0, n};
  endfunction

  assign launch    = (state_q == PH_IDLE) && start && !use_dma;
  assign addr_d    = launch ? dev_addr : lat_addr_q;
  assign dir_d     = launch ? dir_wr   : lat_dir_q;
  assign tx_d      = launch ? tx_word  : lat_tx_q;
  assign cnt_set_d = launch ? counts   : lat_cnt_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    stretch_d  = stretch_q;
    abort_d    = abort_q;
    done_pulse = 1'b0;
    err_pulse  = 1'b0;
    rx_load    = 1'b0;
    sample_en  = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (launch) begin
          state_d   = PH_SETUP;
          cnt_d     = '0;
          stretch_d = '0;
          abort_d   = 1'b0;
        end
      end
      PH_SETUP: begin
        if (reached(cnt_q, lat_cnt_q.setup)) begin
          state_d = PH_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_STROBE: begin
        if (lat_rdy_q && !iordy) begin
          if (stretch_q == SW'(STRETCH_MAX - 1)) begin
            abort_d = 1'b1;
            state_d = PH_RECOVER;
            cnt_d   = '0;
          end else begin
            stretch_d = stretch_q + 1'b1;
          end
        end else if (reached(cnt_q, lat_cnt_q.strobe)) begin
          state_d   = PH_RECOVER;
          cnt_d     = '0;
          sample_en = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_RECOVER: begin
        if (reached(cnt_q, lat_cnt_q.recover)) begin
          state_d    = PH_IDLE;
          cnt_d      = '0;
          done_pulse = 1'b1;
          err_pulse  = abort_q;
          rx_load    = !lat_dir_q && !abort_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PH_IDLE;
      cnt_q      <= '0;
      stretch_q  <= '0;
      abort_q    <= 1'b0;
      lat_addr_q <= '0;
      lat_dir_q  <= 1'b0;
      lat_rdy_q  <= 1'b0;
      lat_tx_q   <= '0;
      lat_cnt_q  <= '0;
      sample_q   <= '0;
      cs_n       <= 2'b11;
      da         <= '0;
      dior_n     <= 1'b1;
      diow_n     <= 1'b1;
      dd_out     <= '0;
      dd_oe      <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      stretch_q <= stretch_d;
      abort_q   <= abort_d;
      if (launch) begin
        lat_addr_q <= dev_addr;
        lat_dir_q  <= dir_wr;
        lat_rdy_q  <= rdy_en;
        lat_tx_q   <= tx_word;
        lat_cnt_q  <= counts;
      end
      if (sample_en) sample_q <= dd_in;
      // Bus pins are registered from the next phase so they line up with it.
      if (state_d == PH_IDLE) begin
        cs_n <= 2'b11;
        da   <= '0;
      end else begin
        cs_n <= addr_d[3] ? 2'b01 : 2'b10;
        da   <= addr_d[2:0];
      end
      dior_n <= !((state_d == PH_STROBE) && !dir_d);
      diow_n <= !((state_d == PH_STROBE) && dir_d);
      dd_out <= tx_d;
      dd_oe  <= dir_d && ((state_d == PH_SETUP) || (state_d == PH_STROBE) ||
                          ((state_d == PH_RECOVER) && (cnt_d < cnt_set_d.hold)));
    end
  end

  assign busy    = (state_q != PH_IDLE);
  assign rx_word = sample_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n)); // R3

  AST_CS_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> (cs_n != 2'b11)); // R5

  AST_NO_READ_WHILE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    dd_oe |-> dior_n); // R6

  AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (rst)
    stretch_q < SW'(STRETCH_MAX)); // R11

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(lat_addr_q) && $stable(lat_dir_q) && $stable(lat_tx_q))); // R12

endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
  import pata_pio_pkg::*;
#(
  parameter int         DW          = 16,
  parameter int         STRETCH_MAX = 1250,
  parameter logic [3:0] DATA_ADDR   = 4'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [REG_AW-1:0] cfg_wr_addr,
  input  logic [DW-1:0]     cfg_wr_data,
  input  logic [REG_AW-1:0] cfg_rd_addr,
  output logic [DW-1:0]     cfg_rd_data,
  output logic              irq,
  output logic [1:0]        ata_cs_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DW-1:0]     ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DW-1:0]     ata_dd_in,
  input  logic              ata_iordy
);

  logic          start_pulse, ctrl_wr, ctrl_dma, ctrl_rdy;
  logic [3:0]    dev_addr;
  logic [DW-1:0] tx_word, rx_word;
  logic [15:0]   tim_reg, tim_pio0;
  logic [7:0]    tim_pio1;
  logic          busy, done_pulse, err_pulse, rx_load;
  phase_counts_t counts;

  pata_pio_regs #(.DW(DW)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_wr_en),
    .wr_addr     (cfg_wr_addr),
    .wr_data     (cfg_wr_data),
    .rd_addr     (cfg_rd_addr),
    .rd_data     (cfg_rd_data),
    .start_pulse (start_pulse),
    .ctrl_wr     (ctrl_wr),
    .ctrl_dma    (ctrl_dma),
    .ctrl_rdy    (ctrl_rdy),
    .dev_addr    (dev_addr),
    .tx_word     (tx_word),
    .tim_reg     (tim_reg),
    .tim_pio0    (tim_pio0),
    .tim_pio1    (tim_pio1),
    .irq         (irq),
    .busy        (busy),
    .done_set    (done_pulse),
    .err_set     (err_pulse),
    .rx_load     (rx_load),
    .rx_word_in  (rx_word)
  );

  pata_pio_timing_sel #(.DATA_ADDR(DATA_ADDR)) sel_i (
    .tim_reg  (tim_reg),
    .tim_pio0 (tim_pio0),
    .tim_pio1 (tim_pio1),
    .dev_addr (dev_addr),
    .counts   (counts)
  );

  pata_pio_seq #(.DW(DW), .STRETCH_MAX(STRETCH_MAX)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start_pulse),
    .dir_wr     (ctrl_wr),
    .use_dma    (ctrl_dma),
    .rdy_en     (ctrl_rdy),
    .dev_addr   (dev_addr),
    .tx_word    (tx_word),
    .counts     (counts),
    .iordy      (ata_iordy),
    .dd_in      (ata_dd_in),
    .cs_n       (ata_cs_n),
    .da         (ata_da),
    .dior_n     (ata_dior_n),
    .diow_n     (ata_diow_n),
    .dd_out     (ata_dd_out),
    .dd_oe      (ata_dd_oe),
    .busy       (busy),
    .done_pulse (done_pulse),
    .err_pulse  (err_pulse),
    .rx_load    (rx_load),
    .rx_word    (rx_word)
  );

endmodule

// File: tb/pata_pio_engine_tb_top.sv
module pata_pio_engine_tb_top;

  localparam int LIMIT = 1250;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_addr = '0;
  logic [15:0] cfg_wr_data = '0;
  logic [3:0]  cfg_rd_addr = '0;
  logic [15:0] cfg_rd_data;
  logic        irq;
  logic [1:0]  ata_cs_n;
  logic [2:0]  ata_da;
  logic        ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = '0;
  logic        ata_iordy = 1'b1;

  always #4 clk = ~clk;

  pata_pio_engine #(.STRETCH_MAX(LIMIT)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data), .irq(irq),
    .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int m_setup, m_strobe, m_rec, m_oe_post, m_bad_cs, m_bad_da, m_bad_dout, m_wrong, m_done;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output int v);
    @(negedge clk);
    cfg_rd_addr = a;
    @(negedge clk);
    v = int'(cfg_rd_data);
  endtask

  function automatic int at1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Launch one transfer and measure each phase at the pins.
  task automatic xfer(input logic [3:0] a, input logic dir, input logic [15:0] tx,
                      input logic [15:0] rxv, input int iolow, input logic rdy_en);
    int seen_cs, seen_str, low_left;
    logic act, str;
    m_setup = 0; m_strobe = 0; m_rec = 0; m_oe_post = 0;
    m_bad_cs = 0; m_bad_da = 0; m_bad_dout = 0; m_wrong = 0; m_done = 0;
    seen_cs = 0; seen_str = 0; low_left = 0;
    wreg(4'd1, {12'd0, a});
    wreg(4'd2, tx);
    ata_dd_in = rxv;
    wreg(4'd0, {12'd0, rdy_en, 1'b0, dir, 1'b1});
    for (int i = 0; i < 6000 && m_done == 0; i++) begin
      @(negedge clk);
      if (low_left > 0) begin
        low_left--;
        if (low_left == 0) ata_iordy = 1'b1;
      end
      act = (ata_cs_n != 2'b11);
      str = !ata_dior_n || !ata_diow_n;
      if (act) begin
        seen_cs = 1;
        if (ata_cs_n != (a[3] ? 2'b01 : 2'b10)) m_bad_cs++;
        if (ata_da != a[2:0]) m_bad_da++;
        if (str) begin
          if (seen_str == 0) begin
            seen_str = 1;
            if (iolow > 0) begin ata_iordy = 1'b0; low_left = iolow; end
          end
          m_strobe++;
          if ((dir && !ata_dior_n) || (!dir && !ata_diow_n)) m_wrong++;
          if (dir && (!ata_dd_oe || ata_dd_out != tx)) m_bad_dout++;
          if (!dir && ata_dd_oe) m_bad_dout++;
        end else if (seen_str == 0) begin
          m_setup++;
          if (dir && (!ata_dd_oe || ata_dd_out != tx)) m_bad_dout++;
        end else begin
          m_rec++;
          if (ata_dd_oe) m_oe_post++;
        end
      end else if (seen_cs != 0) begin
        m_done = 1;
      end
    end
    ata_iordy = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int v, k, prev_rx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cs_n", int'(ata_cs_n), 3);
    check("R1 strobes", int'({ata_dior_n, ata_diow_n}), 3);
    check("R1 oe", int'(ata_dd_oe), 0);
    check("R1 irq", int'(irq), 0);
    rreg(4'd7, v); check("R1 status", v, 0);
    rreg(4'd8, v); check("R1 mask", v, 0);

    // Sweep of timing counts over both count sets, both directions.
    k = 0;
    prev_rx = 0;
    for (int t1 = 0; t1 < 4; t1++) begin
      for (int te = 0; te < 5; te++) begin
        for (int t2 = 0; t2 < 4; t2++) begin
          logic [3:0] a;
          logic dir;
          int t4, e_str, e_rec, e_oe;
          logic [15:0] txv, rxv;
          t4  = (te + t2) % 4;
          dir = k[0];
          a   = (k % 3 == 0) ? 4'd0 : ((k % 3 == 1) ? 4'(8 + (k % 8)) : 4'(1 + (k % 7)));
          txv = 16'(16'hA5C3 ^ (k * 16'h0131));
          rxv = 16'(16'h3C5A + k * 16'h0207);
          wreg(4'd4, {8'(te), 8'(t2)});
          wreg(4'd5, {4'(t4), 8'(t2 + 2), 4'(t1)});
          wreg(4'd6, 16'(te + 1));
          xfer(a, dir, txv, rxv, 0, 1'b0);
          e_str = (a == 4'd0) ? te + 1 : at1(te);
          e_rec = (a == 4'd0) ? t2 + 2 : at1(t2);
          e_oe  = dir ? ((at1(t4) < e_rec) ? at1(t4) : e_rec) : 0;
          check("R2 setup clocks", m_setup, at1(t1));
          check("R3 strobe clocks", m_strobe, e_str);
          check("R3 strobe polarity", m_wrong, 0);
          check("R4 recovery clocks", m_rec, e_rec);
          check("R5 chip select", m_bad_cs, 0);
          check("R5 address lines", m_bad_da, 0);
          check("R6 data drive", m_bad_dout, 0);
          check("R6 write hold", m_oe_post, e_oe);
          rreg(4'd7, v); check("R8 done set", v, 1);
          rreg(4'd3, v);
          if (!dir) prev_rx = int'(rxv);
          check("R7 receive word", v, prev_rx);
          wreg(4'd7, 16'h0001);
          rreg(4'd7, v); check("R8 done cleared", v, 0);
          k++;
        end
      end
    end

    // R8/R9 sticky done and interrupt gating
    wreg(4'd4, 16'h0202);
    wreg(4'd5, 16'h1011);
    xfer(4'd2, 1'b0, 16'h0, 16'h1234, 0, 1'b0);
    wreg(4'd7, 16'h0000);
    rreg(4'd7, v); check("R8 write 0 keeps done", v, 1);
    check("R9 irq masked", int'(irq), 0);
    wreg(4'd8, 16'h0001);
    @(negedge clk);
    check("R9 irq raised", int'(irq), 1);
    wreg(4'd7, 16'h0001);
    @(negedge clk);
    check("R9 irq drops with done", int'(irq), 0);
    wreg(4'd8, 16'h0000);

    // R10 ready stretching
    xfer(4'd3, 1'b0, 16'h0, 16'h4321, 3, 1'b1);
    check("R10 stretched strobe", m_strobe, 2 + 3);
    rreg(4'd3, v); check("R10 read after stretch", v, 16'h4321);
    wreg(4'd7, 16'h0001);
    xfer(4'd3, 1'b1, 16'h7777, 16'h0, 4, 1'b0);
    check("R10 ready disabled", m_strobe, 2);
    wreg(4'd7, 16'h0001);

    // R11 stretch limit
    xfer(4'd4, 1'b0, 16'h0, 16'hBEEF, 2000, 1'b1);
    check("R11 strobe capped", m_strobe, LIMIT);
    check("R11 recovery still runs", m_rec, 2);
    rreg(4'd7, v); check("R11 error and done", v, 3);
    rreg(4'd3, v); check("R11 receive unchanged", v, 16'h4321);
    wreg(4'd7, 16'h0003);
    rreg(4'd7, v); check("R11 flags cleared", v, 0);

    // R12/R13 launch while busy, launch with DMA bit
    begin
      int idle_bad, n_str, da_bad;
      wreg(4'd4, 16'h6402);
      wreg(4'd1, 16'h0005);
      wreg(4'd0, 16'h0001);
      repeat (4) @(negedge clk);
      rreg(4'd7, v); check("R13 busy during transfer", v, 4);
      wreg(4'd1, 16'h0009);
      wreg(4'd2, 16'h5555);
      wreg(4'd0, 16'h0003);
      da_bad = 0; n_str = 0; idle_bad = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (ata_cs_n != 2'b11 && (ata_da != 3'd5 || ata_cs_n != 2'b10)) da_bad++;
        if (!ata_diow_n) n_str++;
        if (i > 150 && ata_cs_n != 2'b11) idle_bad++;
      end
      check("R12 running cycle unchanged", da_bad, 0);
      check("R12 no write strobe from ignored launch", n_str, 0);
      check("R12 no second cycle", idle_bad, 0);
      rreg(4'd7, v); check("R13 idle after done", v, 1);
      wreg(4'd7, 16'h0001);
      wreg(4'd0, 16'h0007);
      idle_bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (ata_cs_n != 2'b11 || !ata_dior_n || !ata_diow_n) idle_bad++;
      end
      check("R12 DMA bit blocks launch", idle_bad, 0);
      rreg(4'd7, v); check("R12 no done with DMA bit", v, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule